// File: doc/BRIEF.md
# Biphase-mark frame-aligning decoder

This block receives a serial audio line in biphase-mark code. The line is sampled once per half bit cell by an externally supplied clock that runs at 128 times the audio sample rate. A sliding window of eight half-cell samples looks for the code-violating patterns that open a frame. These are the block-start and left-channel preambles. When either appears, the block raises a one-cycle frame-start pulse and realigns its divide-by-two phase so that data sampling begins on a bit-cell boundary. It also restarts its bit-slot numbering, so downstream sub-frame counting stays in step. The right-channel preamble is never reported.

Each recovered bit is the XOR of the two half-cell samples of its cell, so the absolute line polarity does not matter. The bit is presented together with a one-cycle strobe on every second clock, and it carries its slot number within the 64-slot frame. The four slots that hold each sub-frame's preamble are flagged, so that downstream logic can skip them. No strobe is produced until the first frame preamble has been seen. After a phase slip, the block falls back into step at the next frame preamble without any external framing signal.

Top module: `bmark_frame_decoder`

## Requirements
- R1: While reset is asserted, and until the first line activity, bit_out, bit_stb, frame_start, hdr_slot and slot_idx are all 0.
- R2: The window holds samples with the earliest one leftmost. When the window holds the block-start preamble 11101000, or its inverse 00010111, frame_start is high for exactly one clock. That clock follows the edge that sampled the eighth cell.
- R3: The left-channel preamble 11100010, or its inverse 00011101, raises frame_start with the same timing as R2.
- R4: The right-channel preamble 11100100, or its inverse 00011011, raises no frame_start. It does not alter the phase or the slot numbering.
- R5: bit_stb stays 0 until a block-start or left-channel preamble has been detected, even when valid data and right-channel preambles arrive first.
- R6: Once locked, bit_stb is high for one clock, one clock after the edge that sampled the second half of each bit cell. It is never high on two consecutive clocks.
- R7: With bit_stb high, bit_out is 1 when the two half cells of that bit differ and 0 when they are equal. This holds for either line polarity.
- R8: slot_idx numbers the 64 bit slots of a frame. The preamble occupies slots 0 to 3, so the first data slot after a frame preamble is 4. The right preamble sits at slots 32 to 35. hdr_slot is 1 exactly when slot_idx modulo 32 is below 4.
- R9: After an inserted half cell shifts the line phase, strobes, bits and slots are correct again from the first data bit after the next block-start or left-channel preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell sampling clock (128 x sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Biphase-mark coded serial line |
| bit_out | output | 1 | Recovered bit, valid with bit_stb |
| bit_stb | output | 1 | One-cycle strobe per recovered bit |
| frame_start | output | 1 | One-cycle pulse after a block-start or left preamble |
| slot_idx | output | 6 | Slot of the presented bit within the frame |
| hdr_slot | output | 1 | Presented bit lies in a preamble slot |

## Verification
Each half cell goes through the window register, and each result then goes through one output register. A bit's strobe, value and slot, and the frame-start pulse for a preamble, are therefore due exactly one clock after the edge that samples the bit's second half cell or the preamble's last cell. The bench drives one half cell per falling edge and queues its expectation for that cell. It compares every output on the falling edge two cycles later, so each check lands in the middle of the cycle in which the result is due. Cells between a deliberate phase slip and the next frame preamble are marked don't-care for the strobe fields, while frame_start is still checked there.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // Preamble length in bit slots; the window spans two half cells per slot.
  localparam int PRE_BITS = 4;
  localparam int WIN      = 2 * PRE_BITS;

  // Patterns with the earliest sample in the MSB, for a line that was low
  // before the preamble; the inverse forms are derived where they are used.
  localparam logic [WIN-1:0] PAT_BLOCK = 8'b1110_1000;
  localparam logic [WIN-1:0] PAT_LEFT  = 8'b1110_0010;
  localparam logic [WIN-1:0] PAT_RIGHT = 8'b1110_0100;

  typedef enum logic [1:0] {
    PRE_NONE  = 2'd0,
    PRE_BLOCK = 2'd1,
    PRE_LEFT  = 2'd2,
    PRE_RIGHT = 2'd3
  } pre_kind_e;
endpackage

// File: rtl/bmd_window.sv
module bmd_window
  import bmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic [1:0] pair,
  output pre_kind_e  kind
);
  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_d;
  logic [1:0]     hit_blk;
  logic [1:0]     hit_left;
  logic [1:0]     hit_right;

  always_comb begin
    win_d = {win_q[WIN-2:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  // One comparator set per line polarity.
  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam logic [WIN-1:0] FLIP = (p == 0) ? '0 : '1;
    assign hit_blk[p]   = (win_q == (PAT_BLOCK ^ FLIP));
    assign hit_left[p]  = (win_q == (PAT_LEFT  ^ FLIP));
    assign hit_right[p] = (win_q == (PAT_RIGHT ^ FLIP));
  end

  always_comb begin
    if (|hit_blk) begin
      kind = PRE_BLOCK;
    end else if (|hit_left) begin
      kind = PRE_LEFT;
    end else if (|hit_right) begin
      kind = PRE_RIGHT;
    end else begin
      kind = PRE_NONE;
    end
  end

  assign pair = win_q[1:0];

  // A preamble in the window cannot reappear one shift later.
  AST_FS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != PRE_NONE) |=> (kind == PRE_NONE)); // R2
endmodule

// File: rtl/bmd_phase.sv
module bmd_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic align,
  output logic half,
  output logic locked
);
  logic half_q;
  logic half_d;
  logic locked_q;
  logic locked_d;

  // half_q is 1 when the window's two newest samples form one whole bit cell.
  always_comb begin
    half_d   = align ? 1'b0 : ~half_q;
    locked_d = locked_q | align;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      half_q   <= half_d;
      locked_q <= locked_d;
    end
  end

  assign half   = half_q;
  assign locked = locked_q;
endmodule

// File: rtl/bmd_bitout.sv
module bmd_bitout
  import bmd_pkg::*;
#(
  parameter int SUB_BITS = 32,
  parameter int SUBS     = 2,
  parameter int SLOT_W   = $clog2(SUB_BITS * SUBS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              align,
  input  logic [1:0]        pair,
  output logic              bit_out,
  output logic              bit_stb,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              hdr_slot
);
  localparam int SLOTS = SUB_BITS * SUBS;
  localparam int SUB_W = $clog2(SUB_BITS);
  localparam logic [SLOT_W-1:0] TAIL_SLOT  = SLOT_W'(PRE_BITS - 1);
  localparam logic [SLOT_W-1:0] FIRST_DATA = SLOT_W'(PRE_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SLOT_W-1:0] slot_sel;
  logic [SUB_W-1:0]  sub_pos;
  logic bit_q, bit_d;
  logic stb_q, stb_d;
  logic fs_q, fs_d;
  logic hdr_q, hdr_d;

  always_comb begin
    slot_sel = align ? TAIL_SLOT : cnt_q;
    sub_pos  = slot_sel[SUB_W-1:0];
    stb_d    = emit;
    fs_d     = align;
    bit_d    = bit_q;
    slot_d   = slot_q;
    hdr_d    = hdr_q;
    if (emit) begin
      bit_d  = pair[1] ^ pair[0];
      slot_d = slot_sel;
      hdr_d  = (sub_pos < SUB_W'(PRE_BITS));
    end
    if (align) begin
      cnt_d = FIRST_DATA;
    end else if (emit) begin
      cnt_d = (cnt_q == LAST_SLOT) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
      bit_q  <= 1'b0;
      stb_q  <= 1'b0;
      fs_q   <= 1'b0;
      hdr_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
      stb_q  <= stb_d;
      fs_q   <= fs_d;
      hdr_q  <= hdr_d;
    end
  end

  assign bit_out     = bit_q;
  assign bit_stb     = stb_q;
  assign frame_start = fs_q;
  assign slot_idx    = slot_q;
  assign hdr_slot    = hdr_q;

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R6
  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R3
  AST_FIRST_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ##2 (bit_stb && slot_idx == FIRST_DATA)); // R8
endmodule

// File: rtl/bmark_frame_decoder.sv
module bmark_frame_decoder
  import bmd_pkg::*;
#(
  parameter int SUB_BITS    = 32,
  parameter int SUBS        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = $clog2(SUB_BITS * SUBS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              bit_out,
  output logic              bit_stb,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              hdr_slot
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_int_n;
  logic [1:0]             pair;
  pre_kind_e              kind;
  logic                   align;
  logic                   half;
  logic                   locked;
  logic                   emit;

  // Reset asserts at once and leaves after SYNC_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[SYNC_STAGES-1];

  bmd_window u_window (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_in (line_in),
    .pair    (pair),
    .kind    (kind)
  );

  // Only frame-opening preambles steer phase and numbering.
  assign align = (kind == PRE_BLOCK) || (kind == PRE_LEFT);

  bmd_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .align  (align),
    .half   (half),
    .locked (locked)
  );

  assign emit = half & locked;

  bmd_bitout #(
    .SUB_BITS (SUB_BITS),
    .SUBS     (SUBS),
    .SLOT_W   (SLOT_W)
  ) u_bitout (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .emit        (emit),
    .align       (align),
    .pair        (pair),
    .bit_out     (bit_out),
    .bit_stb     (bit_stb),
    .frame_start (frame_start),
    .slot_idx    (slot_idx),
    .hdr_slot    (hdr_slot)
  );
endmodule

// File: tb/bmark_frame_decoder_tb.sv
module bmark_frame_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b0;
  logic       bit_out, bit_stb, frame_start, hdr_slot;
  logic [5:0] slot_idx;

  always #2 clk = ~clk;

  bmark_frame_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_out(bit_out),
    .bit_stb(bit_stb), .frame_start(frame_start), .slot_idx(slot_idx),
    .hdr_slot(hdr_slot)
  );

  typedef struct {
    bit stb; bit b; int slot; bit fs; bit dc; bit rl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit lvl = 1'b0;
  bit locked_b = 1'b0;
  bit resync = 1'b0;
  bit relocked = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic verify(exp_t e);
    string sfx = e.rl ? " R9" : "";
    chk(frame_start === e.fs, {"R2 R3 R4 frame_start", sfx}, frame_start, e.fs);
    if (!e.dc) begin
      chk(bit_stb === e.stb, {"R5 R6 bit_stb", sfx}, bit_stb, e.stb);
      if (e.stb) begin
        chk(bit_out === e.b, {"R7 bit_out", sfx}, bit_out, e.b);
        chk(slot_idx === 6'(e.slot), {"R8 slot_idx", sfx}, slot_idx, e.slot);
        chk(hdr_slot === ((e.slot % 32) < 4), {"R8 hdr_slot", sfx},
            hdr_slot, int'((e.slot % 32) < 4));
      end
    end
  endtask

  // Drive one half cell; its results are due two falling edges later.
  task automatic put_cell(bit v, exp_t e);
    @(negedge clk);
    if (q.size() == 2) verify(q.pop_front());
    line_in = v;
    q.push_back(e);
  endtask

  function automatic exp_t mk(bit stb, bit b, int slot, bit fs, bit dc);
    exp_t e;
    e.stb = stb; e.b = b; e.slot = slot; e.fs = fs; e.dc = dc; e.rl = relocked;
    return e;
  endfunction

  function automatic bit next_data();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_bit(bit d, int s);
    bit c0 = ~lvl;
    bit c1 = d ? ~c0 : c0;
    put_cell(c0, mk(1'b0, 1'b0, 0, 1'b0, resync));
    put_cell(c1, mk(locked_b, c0 ^ c1, s, 1'b0, resync));
    lvl = c1;
  endtask

  // kind: 0 block-start, 1 left, 2 right
  task automatic send_pre(int kind, int base);
    logic [7:0] p = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
    if (lvl) p = ~p;
    for (int i = 0; i < 4; i++) begin
      bit c0 = p[7 - 2*i];
      bit c1 = p[6 - 2*i];
      bit tail = (i == 3) && (kind != 2);
      put_cell(c0, mk(1'b0, 1'b0, 0, 1'b0, resync));
      put_cell(c1, mk(locked_b, c0 ^ c1, base + i, tail, resync));
      if (tail) begin
        locked_b = 1'b1;
        resync = 1'b0;
      end
    end
    lvl = p[0];
  endtask

  task automatic send_data(int from, int to);
    for (int s = from; s <= to; s++) send_bit(next_data(), s);
  endtask

  task automatic send_frame(bit blk);
    send_pre(blk ? 0 : 1, 0);
    send_data(4, 31);
    send_pre(2, 32);
    send_data(36, 63);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(bit_stb === 1'b0 && frame_start === 1'b0, "R1 reset strobes", bit_stb, 0);
      chk(bit_out === 1'b0 && hdr_slot === 1'b0 && slot_idx === 6'd0,
          "R1 reset data", slot_idx, 0);
    end
    rst_n = 1'b1;
    repeat (6) put_cell(1'b0, mk(1'b0, 1'b0, 0, 1'b0, 1'b0));
    // R5 R4: join mid right sub-frame; no strobes before the first frame preamble
    send_data(40, 63);
    send_frame(1'b1);            // R2 block-start: lock
    send_frame(1'b0);            // R3 left
    send_frame(1'b0);
    send_frame(1'b0);
    // R9: slip by one half cell inside the left sub-frame
    send_pre(1, 0);
    send_data(4, 14);
    resync = 1'b1;
    put_cell(~lvl, mk(1'b0, 1'b0, 0, 1'b0, 1'b1));
    lvl = ~lvl;
    send_data(15, 31);
    send_pre(2, 32);
    send_data(36, 63);
    relocked = 1'b1;
    send_frame(1'b0);
    send_frame(1'b1);
    relocked = 1'b0;
    repeat (4) put_cell(1'b0, mk(1'b0, 1'b0, 0, 1'b0, 1'b1));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule